// File: doc/BRIEF.md
# Object Handle Hash Table Engine

This block keeps a table of object handles in on-chip storage and resolves them by hashing. Each slot holds three things: a 32-bit handle, a 32-bit context word and a channel tag. A command carries a handle and a channel id, and it asks for one of three operations: lookup, insert or remove. An insert also carries an engine code and an instance address. From these the block builds the context word that it stores. The starting slot is found by XOR-folding the handle in table-width chunks and then mixing in the channel at a fixed shift. Collisions are resolved by linear probing. The probe steps forward one slot per clock and wraps from the last slot back to slot 0.

Commands enter on a valid/ready port. `cmd_ready` is high only while the engine is idle. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. While a command is being probed, `cmd_ready` stays low and `cmd_valid` is ignored. Results leave as a one-cycle `rsp_valid` pulse that carries a status, a slot index and a context word. The response has no back-pressure, so the consumer must take it in the cycle it appears. The context word layout is chosen per command by `fmt_alt`.

Top module: `obj_handle_table`

## Requirements
- R1: On an empty table, an insert lands in the slot given by the hash. The hash XORs the handle's HT_BITS-wide chunks together, starting from bit 0 until all 32 bits are used (the last chunk is zero-padded). It then XORs in the channel id shifted left by HT_BITS-4, and keeps the low HT_BITS bits.
- R2: A probe that meets an occupied, non-matching slot moves to the next slot index. Slot 2^HT_BITS-1 is followed by slot 0. Each probe costs one clock, so a command ending at probe distance d raises `rsp_valid` d+1 cycles after the accept edge.
- R3: A slot is empty when its handle word is zero. Any command ends at the first empty slot it reaches. At that point lookup and remove report miss (status 1), and insert writes there and reports ok (status 0).
- R4: If an insert probes every slot without finding an empty one, it reports full (status 2) after 2^HT_BITS probes and changes no entry.
- R5: With `fmt_alt`=0, the context word has bit 31 set and the channel in bits 28:24. The engine code sits in bits 17:16 and `cmd_inst[19:4]` in bits 15:0. All other bits are zero.
- R6: With `fmt_alt`=1, the context word has the engine code in bits 21:20 and `cmd_inst[19:4]` in bits 15:0. All other bits, bit 31 included, are zero.
- R7: A command with handle zero is answered as a miss with slot 0 and context 0, with `rsp_valid` in the cycle after acceptance. Such a command writes nothing.
- R8: Lookup (`cmd_op`=0, or the unused code 3) reports ok with the stored context word. It does so only on a slot whose handle equals the requested handle and whose channel tag equals the requested channel. A slot whose handle matches but whose channel differs is probed past.
- R9: An insert (`cmd_op`=1) that finds its handle and channel already present reports duplicate (status 3). It returns that slot and its stored context word, and writes nothing.
- R10: Remove (`cmd_op`=2) of a present entry reports ok with its slot and prior context word, then clears the slot to zero. A later lookup of that handle then misses.
- R11: `cmd_ready` is high after reset and whenever no command is in progress. It is low from the accept edge until the response cycle, and `rsp_valid` is low out of reset.
- R12: Miss and full responses carry slot 0 and context word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; empties the table |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle; command taken when both are high |
| cmd_op | input | 2 | 0 lookup, 1 insert, 2 remove, 3 lookup |
| cmd_handle | input | 32 | Object handle |
| cmd_chan | input | 5 | Channel id |
| cmd_engine | input | 2 | Engine code (insert) |
| cmd_inst | input | 20 | Instance byte address (insert) |
| fmt_alt | input | 1 | Context word layout select (insert) |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_status | output | 2 | 0 ok, 1 miss, 2 full, 3 duplicate |
| rsp_slot | output | HT_BITS | Slot index of the entry |
| rsp_ctx | output | 32 | Context word of the entry |

## Verification
The bench sweeps many handles and channels through an empty table and compares every slot with the arithmetic fold. A wrong chunk boundary or channel shift would put entries in the wrong slot. Runs of colliding handles push the probe across the wrap from the top slot to slot 0. A hole is cut into a chain to show that probing stops at the first empty slot. A missing wrap or a probe that skips empties would return the wrong slot or latency. The same handle is stored on two channels that hash alike, so a design that ignores the channel tag would return the wrong entry or report a false duplicate. The table is then filled completely: an insert that wrote on a full table, or gave up before trying every slot, shows up as a wrong status, a wrong latency or a lost entry.

// File: rtl/hht_pkg.sv
package hht_pkg;
  localparam int CHAN_W = 5;
  localparam int ENG_W  = 2;
  localparam int INST_W = 20;
  localparam int CTX_W  = 32;
  localparam int HDL_W  = 32;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_INSERT = 2'd1,
    OP_REMOVE = 2'd2,
    OP_SPARE  = 2'd3
  } hht_op_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_MISS = 2'd1,
    ST_FULL = 2'd2,
    ST_DUP  = 2'd3
  } hht_status_e;

  typedef struct packed {
    logic [HDL_W-1:0]  handle;
    logic [CTX_W-1:0]  ctx;
    logic [CHAN_W-1:0] chan;
  } hht_entry_t;
endpackage

// File: rtl/hht_hash.sv
module hht_hash
  import hht_pkg::*;
#(
  parameter int HT_BITS = 6
) (
  input  logic [HDL_W-1:0]   handle,
  input  logic [CHAN_W-1:0]  chan,
  output logic [HT_BITS-1:0] idx
);
  localparam int NCHUNK = (HDL_W + HT_BITS - 1) / HT_BITS;
  localparam int PADW   = NCHUNK * HT_BITS;
  localparam int SHIFT  = HT_BITS - 4;

  logic [PADW-1:0]    padded;
  logic [HT_BITS-1:0] fold [NCHUNK+1];
  logic [HT_BITS-1:0] chan_mix;

  assign padded  = PADW'(handle);
  assign fold[0] = '0;

  // one XOR stage per chunk, lowest chunk first
  for (genvar g = 0; g < NCHUNK; g++) begin : g_fold
    assign fold[g+1] = fold[g] ^ padded[g*HT_BITS +: HT_BITS];
  end

  assign chan_mix = HT_BITS'(chan) << SHIFT;
  assign idx      = fold[NCHUNK] ^ chan_mix;
endmodule

// File: rtl/hht_ctx_pack.sv
module hht_ctx_pack
  import hht_pkg::*;
(
  input  logic              alt,
  input  logic [CHAN_W-1:0] chan,
  input  logic [ENG_W-1:0]  engine,
  input  logic [INST_W-1:0] inst,
  output logic [CTX_W-1:0]  ctx
);
  logic [15:0] inst_units;
  logic        unused_low;

  assign inst_units = inst[INST_W-1:4];
  assign unused_low = ^inst[3:0];

  always_comb begin
    if (alt) begin
      ctx        = '0;
      ctx[21:20] = engine;
      ctx[15:0]  = inst_units;
    end else begin
      ctx = {1'b1, 2'b00, chan, 6'b000000, engine, inst_units};
    end
  end
endmodule

// File: rtl/hht_table.sv
module hht_table
  import hht_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [AW-1:0] wr_addr,
  input  hht_entry_t wr_data,
  input  logic       rd_en,
  input  logic [AW-1:0] rd_addr,
  output hht_entry_t rd_data
);
  hht_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (rd_en) rd_data <= mem[rd_addr];
    end
  end

  // R3 a probe read never coincides with the write that ends a command
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));
endmodule

// File: rtl/obj_handle_table.sv
module obj_handle_table
  import hht_pkg::*;
#(
  parameter int HT_BITS = 6,
  localparam int DEPTH = 1 << HT_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [31:0]        cmd_handle,
  input  logic [4:0]         cmd_chan,
  input  logic [1:0]         cmd_engine,
  input  logic [19:0]        cmd_inst,
  input  logic               fmt_alt,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [HT_BITS-1:0] rsp_slot,
  output logic [31:0]        rsp_ctx
);
  typedef enum logic {S_IDLE, S_EVAL} state_e;

  state_e             state;
  logic [1:0]         op_q;
  logic [HDL_W-1:0]   handle_q;
  logic [CHAN_W-1:0]  chan_q;
  logic [CTX_W-1:0]   ctx_new_q;
  logic [HT_BITS-1:0] start_idx, probe_idx, next_idx;
  logic [HT_BITS-1:0] hash_idx;
  logic [CTX_W-1:0]   ctx_new;

  logic       accept, zero_hdl;
  logic       is_ins, is_rem;
  logic       slot_empty, slot_match, wrapped, finish;
  logic       rd_en, wr_en;
  logic [HT_BITS-1:0] rd_addr;
  hht_entry_t rd_data, wr_data;

  hht_hash #(.HT_BITS(HT_BITS)) u_hash (
    .handle (cmd_handle),
    .chan   (cmd_chan),
    .idx    (hash_idx)
  );

  hht_ctx_pack u_pack (
    .alt    (fmt_alt),
    .chan   (cmd_chan),
    .engine (cmd_engine),
    .inst   (cmd_inst),
    .ctx    (ctx_new)
  );

  hht_table #(.DEPTH(DEPTH)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (probe_idx),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign zero_hdl  = (cmd_handle == '0);

  assign is_ins = (op_q == OP_INSERT);
  assign is_rem = (op_q == OP_REMOVE);

  // evaluation of the slot whose read returned this cycle
  assign slot_empty = (rd_data.handle == '0);
  assign slot_match = (rd_data.handle == handle_q) && (rd_data.chan == chan_q);
  assign next_idx   = probe_idx + HT_BITS'(1);
  assign wrapped    = (next_idx == start_idx);
  assign finish     = slot_empty || slot_match || wrapped;

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = hash_idx;
    if (state == S_IDLE) begin
      rd_en   = accept && !zero_hdl;
      rd_addr = hash_idx;
    end else if (!finish) begin
      rd_en   = 1'b1;
      rd_addr = next_idx;
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_data = '0;
    if (state == S_EVAL) begin
      if (slot_empty && is_ins) begin
        wr_en   = 1'b1;
        wr_data = '{handle: handle_q, ctx: ctx_new_q, chan: chan_q};
      end else if (!slot_empty && slot_match && is_rem) begin
        wr_en   = 1'b1;
        wr_data = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_q       <= OP_LOOKUP;
      handle_q   <= '0;
      chan_q     <= '0;
      ctx_new_q  <= '0;
      start_idx  <= '0;
      probe_idx  <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_slot   <= '0;
      rsp_ctx    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            op_q      <= cmd_op;
            handle_q  <= cmd_handle;
            chan_q    <= cmd_chan;
            ctx_new_q <= ctx_new;
            start_idx <= hash_idx;
            probe_idx <= hash_idx;
            if (zero_hdl) begin
              rsp_valid  <= 1'b1;
              rsp_status <= ST_MISS;
              rsp_slot   <= '0;
              rsp_ctx    <= '0;
            end else begin
              state <= S_EVAL;
            end
          end
        end
        S_EVAL: begin
          if (finish) begin
            state     <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_slot  <= '0;
            rsp_ctx   <= '0;
            if (slot_empty) begin
              if (is_ins) begin
                rsp_status <= ST_OK;
                rsp_slot   <= probe_idx;
                rsp_ctx    <= ctx_new_q;
              end else begin
                rsp_status <= ST_MISS;
              end
            end else if (slot_match) begin
              rsp_status <= is_ins ? ST_DUP : ST_OK;
              rsp_slot   <= probe_idx;
              rsp_ctx    <= rd_data.ctx;
            end else begin
              rsp_status <= is_ins ? ST_FULL : ST_MISS;
            end
          end else begin
            probe_idx <= next_idx;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  probe_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_EVAL && $past(state) == S_EVAL) |->
      (probe_idx == $past(probe_idx) + HT_BITS'(1)));

  // R4
  full_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == ST_FULL) |-> (!$past(wr_en) && op_q == OP_INSERT));

  // R9
  dup_only_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == ST_DUP) |-> (op_q == OP_INSERT && !$past(wr_en)));

  // R7
  zero_handle_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && zero_hdl) |=> (rsp_valid && rsp_status == ST_MISS && cmd_ready));

  // R11
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !zero_hdl) |=> !cmd_ready);

  // R12
  miss_zero_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_status == ST_MISS || rsp_status == ST_FULL)) |->
      (rsp_slot == '0 && rsp_ctx == '0));
endmodule

// File: tb/tb_obj_handle_table.sv
module tb_obj_handle_table;
  localparam int HT_BITS = 6;
  localparam int DEPTH   = 1 << HT_BITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_handle = '0;
  logic [4:0]  cmd_chan = '0;
  logic [1:0]  cmd_engine = '0;
  logic [19:0] cmd_inst = '0;
  logic        fmt_alt = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [HT_BITS-1:0] rsp_slot;
  logic [31:0] rsp_ctx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] m_h [DEPTH];
  logic [4:0]  m_c [DEPTH];
  logic [31:0] m_x [DEPTH];

  always #5 clk = ~clk;

  obj_handle_table #(.HT_BITS(HT_BITS)) dut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_handle(cmd_handle), .cmd_chan(cmd_chan),
    .cmd_engine(cmd_engine), .cmd_inst(cmd_inst), .fmt_alt(fmt_alt),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_slot(rsp_slot), .rsp_ctx(rsp_ctx)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int ref_hash(input logic [31:0] h, input logic [4:0] ch);
    int v = 0;
    for (int i = 0; i < 32; i += HT_BITS) v ^= int'((h >> i) % DEPTH);
    v ^= int'(ch) * (1 << (HT_BITS - 4));
    return v % DEPTH;
  endfunction

  function automatic logic [31:0] ref_ctx(input logic alt, input logic [4:0] ch,
                                          input logic [1:0] eng, input logic [19:0] inst);
    logic [31:0] units = 32'(inst / 16);
    if (alt) return (32'(eng) * 32'h0010_0000) + units;
    return 32'h8000_0000 + (32'(ch) * 32'h0100_0000) + (32'(eng) * 32'h0001_0000) + units;
  endfunction

  task automatic model(input logic [1:0] op, input logic [31:0] h, input logic [4:0] ch,
                       input logic [31:0] nctx, output int st, output int slot,
                       output logic [31:0] ctx, output int lat);
    int idx;
    st = 1; slot = 0; ctx = '0; lat = 0;
    if (h == 0) return;
    idx = ref_hash(h, ch);
    for (int k = 0; k < DEPTH; k++) begin
      lat = k + 1;
      if (m_h[idx] == 0) begin
        if (op == 2'd1) begin
          m_h[idx] = h; m_c[idx] = ch; m_x[idx] = nctx;
          st = 0; slot = idx; ctx = nctx;
        end
        return;
      end
      if (m_h[idx] == h && m_c[idx] == ch) begin
        slot = idx; ctx = m_x[idx];
        if (op == 2'd1) st = 3;
        else begin
          st = 0;
          if (op == 2'd2) begin m_h[idx] = 0; m_c[idx] = 0; m_x[idx] = 0; end
        end
        return;
      end
      idx = (idx + 1) % DEPTH;
    end
    st = (op == 2'd1) ? 2 : 1;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [31:0] h, input logic [4:0] ch,
                         input logic [1:0] eng, input logic [19:0] inst, input logic alt,
                         input string tag);
    int e_st, e_slot, e_lat, n;
    logic [31:0] e_ctx;
    model(op, h, ch, ref_ctx(alt, ch, eng, inst), e_st, e_slot, e_ctx, e_lat);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_handle = h; cmd_chan = ch;
    cmd_engine = eng; cmd_inst = inst; fmt_alt = alt;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    n = 0;
    forever begin
      @(negedge clk);
      if (n == 0 && e_lat > 0)
        chk(cmd_ready == 1'b0, "R11", "cmd_ready while busy", cmd_ready, 0);
      if (rsp_valid || n > 200) break;
      @(posedge clk);
      n++;
    end
    chk(rsp_valid == 1'b1, tag, "rsp_valid", rsp_valid, 1);
    chk(int'(rsp_status) == e_st, tag, "status", rsp_status, e_st);
    chk(int'(rsp_slot) == e_slot, tag, "slot", rsp_slot, e_slot);
    chk(rsp_ctx == e_ctx, tag, "ctx", rsp_ctx, e_ctx);
    chk(n == e_lat, "R2", {tag, " latency"}, n, e_lat);
  endtask

  function automatic int free_slots();
    int c = 0;
    for (int i = 0; i < DEPTH; i++) if (m_h[i] == 0) c++;
    return c;
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] h;
    for (int i = 0; i < DEPTH; i++) begin m_h[i] = 0; m_c[i] = 0; m_x[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(cmd_ready == 1'b1, "R11", "cmd_ready after reset", cmd_ready, 1);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", rsp_valid, 0);

    // R7 handle zero: lookup and insert miss at once, nothing stored
    run_cmd(2'd0, 32'h0, 5'd0, 2'd1, 20'h12340, 1'b0, "R7 lookup zero");
    run_cmd(2'd1, 32'h0, 5'd0, 2'd1, 20'h12340, 1'b0, "R7 insert zero");
    run_cmd(2'd1, 32'h41, 5'd0, 2'd2, 20'h00100, 1'b0, "R7 slot0 still free");
    run_cmd(2'd2, 32'h41, 5'd0, 2'd0, 20'h0, 1'b0, "R10 remove 0x41");

    // R1 R5 R6 R8 R10 sweep over an empty table
    for (int i = 0; i < 64; i++) begin
      h = (32'h9E37_79B1 * 32'(i + 1)) | 32'h1;
      run_cmd(2'd1, h, 5'(i), 2'(i), 20'(i * 32'h1230), 1'(i), (i % 2) ? "R6 insert" : "R1 R5 insert");
      run_cmd((i % 3 == 0) ? 2'd3 : 2'd0, h, 5'(i), 2'd0, 20'h0, 1'b0, "R8 lookup");
      run_cmd(2'd2, h, 5'(i), 2'd0, 20'h0, 1'b0, "R10 remove");
      run_cmd(2'd0, h, 5'(i), 2'd0, 20'h0, 1'b0, "R10 lookup after remove");
    end

    // R8 channel tag: chan 0 and 16 hash alike
    run_cmd(2'd1, 32'h0000_0ABC, 5'd0, 2'd1, 20'hAAAA0, 1'b0, "R8 insert ch0");
    run_cmd(2'd0, 32'h0000_0ABC, 5'd16, 2'd0, 20'h0, 1'b0, "R8 lookup ch16 miss");
    run_cmd(2'd1, 32'h0000_0ABC, 5'd16, 2'd2, 20'h55550, 1'b1, "R8 insert ch16");
    run_cmd(2'd0, 32'h0000_0ABC, 5'd16, 2'd0, 20'h0, 1'b0, "R8 lookup ch16 hit");
    run_cmd(2'd0, 32'h0000_0ABC, 5'd0, 2'd0, 20'h0, 1'b0, "R8 lookup ch0 hit");

    // R9 duplicate
    run_cmd(2'd1, 32'h0000_0ABC, 5'd0, 2'd3, 20'hFFFF0, 1'b1, "R9 duplicate");

    // R2 wrap from the top slot, R3 hole stops the probe
    run_cmd(2'd1, 32'd63, 5'd0, 2'd1, 20'h00010, 1'b0, "R2 chain a");
    run_cmd(2'd1, 32'd63 << 6, 5'd0, 2'd1, 20'h00020, 1'b0, "R2 chain b wrap");
    run_cmd(2'd1, 32'd63 << 12, 5'd0, 2'd1, 20'h00030, 1'b0, "R2 chain c");
    run_cmd(2'd0, 32'd63 << 12, 5'd0, 2'd0, 20'h0, 1'b0, "R2 lookup c");
    run_cmd(2'd2, 32'd63 << 6, 5'd0, 2'd0, 20'h0, 1'b0, "R10 remove b");
    run_cmd(2'd0, 32'd63 << 12, 5'd0, 2'd0, 20'h0, 1'b0, "R3 hole miss");

    // R4 fill, then full and no write
    for (int k = 0; k < 200 && free_slots() > 0; k++)
      run_cmd(2'd1, 32'h5000 + 32'(k), 5'(k), 2'(k), 20'(k * 16), 1'b0, "R3 fill");
    run_cmd(2'd1, 32'h7777_0001, 5'd3, 2'd1, 20'h0, 1'b0, "R4 full");
    run_cmd(2'd0, 32'h7777_0002, 5'd3, 2'd0, 20'h0, 1'b0, "R12 miss on full");
    for (int k = 0; k < 8; k++)
      run_cmd(2'd0, 32'h5000 + 32'(k * 7), 5'(k * 7), 2'd0, 20'h0, 1'b0, "R4 entries kept");
    run_cmd(2'd0, 32'h0000_0ABC, 5'd16, 2'd0, 20'h0, 1'b0, "R4 entry kept");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule